// File: doc/BRIEF.md
# Daisy-Chain Interrupt Priority Chain

This block links a parameterized number of interrupt-capable device cells in series so that one interrupt acknowledge is granted by position. Each cell holds a pending-request flip-flop that a one-cycle local set pulse raises. Every pending cell pulls down one shared active-low request line. The line is modelled as the AND of the inverted request bits, as an open-drain wire would combine them.

The processor side watches the request line and raises the acknowledge into cell 0. The acknowledge ripples down the chain and passes each idle cell. The first pending cell absorbs it and drives its own vector address onto the vector bus. On the clock edge where the acknowledge drops, the request of the cell that held the grant is cleared. The next acknowledge can then reach a pending cell further down the chain. The acknowledge that leaves the last cell is brought out so that a further chain can be attached.

Top module: `daisy_irq_chain`

## Requirements
- R1: A synchronous active-high reset clears every pending request, so after it `int_n` is 1. Reset overrides a set pulse in the same cycle.
- R2: A set pulse on `set_req[i]` (bit i belongs to cell i) makes cell i pending from the next clock edge. While any cell is pending, `int_n` is 0.
- R3: While no cell is pending, `int_n` is 1, `vec_valid` is 0 and `vec_bus` is zero.
- R4: An idle cell passes the acknowledge it receives to the next cell. With `int_ack` high and no cell pending, `chain_out` is 1.
- R5: With `int_ack` high, the pending cell with the lowest index is selected. `vec_bus` carries its vector (cell i's vector is `cell_vec[i*VEC_W +: VEC_W]`), `vec_valid` is 1 and `chain_out` is 0.
- R6: With `int_ack` low, every cell sees a blocked acknowledge. `vec_valid` is 0, `vec_bus` is zero and `chain_out` is 0.
- R7: On the clock edge where `int_ack` is low and was high in the previous cycle, the cell that was selected in that previous cycle has its request cleared. Other pending cells keep their requests.
- R8: A set pulse to a cell in the same cycle that would clear it wins, so the cell stays pending.
- R9: Holding `int_ack` high for several cycles clears no request. The same cell stays selected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| set_req | input | NUM_CELLS | Per-cell request set pulse, bit i for cell i |
| cell_vec | input | NUM_CELLS*VEC_W | Per-cell vector addresses, packed by cell index |
| int_ack | input | 1 | Acknowledge from the processor into cell 0 |
| int_n | output | 1 | Shared active-low interrupt request line |
| vec_bus | output | VEC_W | Vector of the selected cell, zero when none |
| vec_valid | output | 1 | High while a cell is selected |
| chain_out | output | 1 | Acknowledge leaving the last cell |

## Verification
The assertions check several relations on every cycle:
- an idle line never shows a selection, and the acknowledge then passes straight through;
- a low acknowledge always yields an empty bus and a blocked chain end;
- a selection always means the acknowledge is high and the chain end is blocked;
- a set pulse always pulls the line low one edge later.

Only the bench scenarios show three further behaviours:
- which cell wins among several pending cells;
- that clearing follows the falling acknowledge, one cell per acknowledge, in chain order;
- that a set coinciding with a clear survives.

// File: rtl/daisy_irq_chain.sv
module daisy_irq_chain #(
  parameter int NUM_CELLS = 4,
  parameter int VEC_W     = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NUM_CELLS-1:0]       set_req,
  input  logic [NUM_CELLS*VEC_W-1:0] cell_vec,
  input  logic                       int_ack,
  output logic                       int_n,
  output logic [VEC_W-1:0]           vec_bus,
  output logic                       vec_valid,
  output logic                       chain_out
);

  logic [NUM_CELLS:0]   ack_rip;
  logic [NUM_CELLS-1:0] pend;
  logic [NUM_CELLS-1:0] grant;
  logic [NUM_CELLS-1:0] grant_q;
  logic                 ack_q;
  logic                 ack_fall;

  assign ack_rip[0] = int_ack;
  assign ack_fall   = ack_q & ~int_ack;

  genvar g;
  generate
    for (g = 0; g < NUM_CELLS; g++) begin : g_cell
      assign ack_rip[g+1] = ack_rip[g] & ~pend[g];
      assign grant[g]     = ack_rip[g] & ~ack_rip[g+1];

      always_ff @(posedge clk) begin
        if (rst)
          pend[g] <= 1'b0;
        else if (set_req[g])
          pend[g] <= 1'b1;
        else if (ack_fall && grant_q[g])
          pend[g] <= 1'b0;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      ack_q   <= 1'b0;
      grant_q <= '0;
    end else begin
      ack_q   <= int_ack;
      grant_q <= grant;
    end
  end

  assign int_n     = &(~pend);
  assign vec_valid = |grant;
  assign chain_out = ack_rip[NUM_CELLS];

  always_comb begin
    vec_bus = '0;
    for (int i = 0; i < NUM_CELLS; i++)
      vec_bus = vec_bus | (cell_vec[i*VEC_W +: VEC_W] & {VEC_W{grant[i]}});
  end

endmodule

module daisy_irq_chain_chk #(
  parameter int NUM_CELLS = 4,
  parameter int VEC_W     = 8
) (
  input logic                 clk,
  input logic                 rst,
  input logic [NUM_CELLS-1:0] set_req,
  input logic                 int_ack,
  input logic                 int_n,
  input logic [VEC_W-1:0]     vec_bus,
  input logic                 vec_valid,
  input logic                 chain_out
);

  p_reset_idle_r1: assert property (@(posedge clk) rst |=> int_n);

  p_set_pulls_line_r2: assert property (@(posedge clk) disable iff (rst)
    (|set_req) |=> !int_n);

  p_idle_no_select_r3: assert property (@(posedge clk) disable iff (rst)
    int_n |-> (!vec_valid && vec_bus == '0));

  p_pass_through_r4: assert property (@(posedge clk) disable iff (rst)
    (int_n && int_ack) |-> chain_out);

  p_select_blocks_r5: assert property (@(posedge clk) disable iff (rst)
    vec_valid |-> (int_ack && !chain_out && !int_n));

  p_no_ack_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    !int_ack |-> (!vec_valid && vec_bus == '0 && !chain_out));

endmodule

bind daisy_irq_chain daisy_irq_chain_chk #(.NUM_CELLS(NUM_CELLS), .VEC_W(VEC_W)) u_chk (
  .clk(clk), .rst(rst), .set_req(set_req), .int_ack(int_ack), .int_n(int_n),
  .vec_bus(vec_bus), .vec_valid(vec_valid), .chain_out(chain_out)
);

// File: tb/sim_daisy_irq_chain.sv
module sim_daisy_irq_chain;
  localparam int N = 4;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst;
  logic [N-1:0] set_req;
  logic [N*W-1:0] cell_vec;
  logic         int_ack;
  logic         int_n;
  logic [W-1:0] vec_bus;
  logic         vec_valid;
  logic         chain_out;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  daisy_irq_chain #(.NUM_CELLS(N), .VEC_W(W)) u0 (
    .clk(clk), .rst(rst), .set_req(set_req), .cell_vec(cell_vec),
    .int_ack(int_ack), .int_n(int_n), .vec_bus(vec_bus),
    .vec_valid(vec_valid), .chain_out(chain_out)
  );

  // {set[3:0], ack, exp_int_n, exp_valid, exp_bus[7:0], exp_chain_out}
  localparam int STEPS = 12;
  localparam logic [15:0] TBL [STEPS] = '{
    {4'b0000, 1'b0, 1'b1, 1'b0, 8'h00, 1'b0},
    {4'b0000, 1'b1, 1'b1, 1'b0, 8'h00, 1'b1},
    {4'b0100, 1'b0, 1'b1, 1'b0, 8'h00, 1'b0},
    {4'b1001, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0},
    {4'b0000, 1'b1, 1'b0, 1'b1, 8'h11, 1'b0},
    {4'b0000, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0},
    {4'b0000, 1'b1, 1'b0, 1'b1, 8'h33, 1'b0},
    {4'b0000, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0},
    {4'b0000, 1'b1, 1'b0, 1'b1, 8'h44, 1'b0},
    {4'b0000, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0},
    {4'b0000, 1'b1, 1'b1, 1'b0, 8'h00, 1'b1},
    {4'b0000, 1'b0, 1'b1, 1'b0, 8'h00, 1'b0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [N-1:0] s, input logic a);
    @(negedge clk);
    set_req = s;
    int_ack = a;
    #8;
  endtask

  task automatic expect_out(input string tag, input logic n, input logic v,
                            input logic [W-1:0] b, input logic co);
    chk({tag, " int_n"}, 32'(int_n), 32'(n));
    chk({tag, " vec_valid"}, 32'(vec_valid), 32'(v));
    chk({tag, " vec_bus"}, 32'(vec_bus), 32'(b));
    chk({tag, " chain_out"}, 32'(chain_out), 32'(co));
  endtask

  initial begin
    #(200000 * 20);
    fails++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    cell_vec = {8'h44, 8'h33, 8'h22, 8'h11};
    rst = 1'b1;
    set_req = '0;
    int_ack = 1'b0;
    repeat (2) @(posedge clk);
    #2;
    // R1: reset state
    expect_out("R1 reset", 1'b1, 1'b0, 8'h00, 1'b0);
    @(negedge clk);
    rst = 1'b0;

    // R2 R3 R4 R5 R6 R7: table walk
    for (int k = 0; k < STEPS; k++) begin
      drive(TBL[k][15:12], TBL[k][11]);
      expect_out($sformatf("R2-R7 table step %0d", k),
                 TBL[k][10], TBL[k][9], TBL[k][8:1], TBL[k][0]);
    end

    // R9: a held acknowledge clears nothing
    drive(4'b1010, 1'b0);
    for (int k = 0; k < 3; k++) begin
      drive(4'b0000, 1'b1);
      expect_out("R9 held ack", 1'b0, 1'b1, 8'h22, 1'b0);
    end
    // R7: the fall clears cell 1 only
    drive(4'b0000, 1'b0);
    drive(4'b0000, 1'b1);
    expect_out("R7 next cell", 1'b0, 1'b1, 8'h44, 1'b0);
    // R8: a set coinciding with the clear survives
    drive(4'b1000, 1'b0);
    drive(4'b0000, 1'b1);
    expect_out("R8 set wins", 1'b0, 1'b1, 8'h44, 1'b0);
    drive(4'b0000, 1'b0);
    drive(4'b0000, 1'b1);
    expect_out("R4 chain empty", 1'b1, 1'b0, 8'h00, 1'b1);

    // R1: reset overrides pending requests and a coincident set
    drive(4'b1111, 1'b0);
    drive(4'b0000, 1'b0);
    chk("R2 all pending int_n", 32'(int_n), 32'd0);
    @(negedge clk);
    rst = 1'b1;
    set_req = 4'b0010;
    @(negedge clk);
    rst = 1'b0;
    set_req = '0;
    int_ack = 1'b1;
    #8;
    expect_out("R1 reset clears", 1'b1, 1'b0, 8'h00, 1'b1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule